// File: doc/BRIEF.md
# Dithered PWM and Interval Timer

This block is an 8-bit up-counter with two operating modes. A 2-bit frame counter sits above it. In interval mode the counter restarts each time it equals a reference value, which gives a programmable period. Each of those match events toggles the output. In PWM mode the counter runs freely through 256 states per frame. The output is high while the reference exceeds the count.

A 2-bit extension value lengthens the high phase by one clock in selected frames of a repeating four-frame group. This dithers the duty cycle to a quarter-step resolution while keeping the 8-bit frame rate.

The block raises a match pending flag and an overflow pending flag for an interrupt controller. Software clears them through strobes, and the overflow flag can also be cleared by a hardware acknowledge. A count-enable input lets an external prescaler set the counting rate. Both reference and extension values are written through strobes. In PWM mode they are held in shadow registers until the frame wraps.

Top module: `pwm_interval_timer`

## Requirements
- R1: In interval mode (mode_i=0), an enabled clock at which count_o equals the active reference sets count_o to 0. With reference N and count starting at 0, the period is N+1 enabled clocks; with reference 10H, count_o reads 10H after 16 enabled clocks and 0 after the 17th.
- R2: In interval mode, tmr_out_o toggles on every match event and is otherwise steady.
- R3: In PWM mode (mode_i=1), a match does not clear the counter. The counter increments on each enabled clock and wraps from FFH to 00H.
- R4: In PWM mode, tmr_out_o is a registered output one clock behind count_o. It is high when the frame's reference is greater than the count. In an unstretched frame it is therefore high for exactly `ref` of the 256 clocks.
- R5: The frame counter starts at 0 and advances at each PWM wrap. Frames are numbered 0 to 3, and frame 0 is the first frame. Extension value 00 stretches no frame, 01 stretches frame 1 only, 10 stretches frames 0 and 2, and 11 stretches frames 0, 1 and 2. A stretched frame also drives high on the clock where the count equals the reference, so it is high for ref+1 clocks, with a maximum of 256.
- R6: match_pend_o is set by a match event in either mode. It stays set until match_clr_i is pulsed.
- R7: ovf_pend_o is set when the counter wraps in PWM mode, and it never sets in interval mode. Either ovf_clr_i or ovf_ack_i clears it.
- R8: In interval mode, a reference written through wr_ref_i is used from the next clock on. In PWM mode, reference and extension writes take effect only at the next frame wrap.
- R9: Reset, a sync_clr_i clock, or a change of mode_i clears the count, the frame counter, the output and both pending flags. Pending flags stay at zero while sync_clr_i is held.
- R10: While cnt_en_i is low, the count and frame counter hold and no match or overflow event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_clr_i | input | 1 | Synchronous clear of counters, output and flags |
| cnt_en_i | input | 1 | Count enable (prescaler tick) |
| mode_i | input | 1 | 0 = interval, 1 = PWM |
| wr_ref_i | input | 1 | Reference write strobe |
| ref_i | input | 8 | Reference write data |
| wr_ext_i | input | 1 | Extension write strobe |
| ext_i | input | 2 | Extension write data |
| match_clr_i | input | 1 | Software clear of match pending |
| ovf_clr_i | input | 1 | Software clear of overflow pending |
| ovf_ack_i | input | 1 | Hardware acknowledge of overflow pending |
| tmr_out_o | output | 1 | Timer output (toggle or PWM) |
| match_pend_o | output | 1 | Match pending flag |
| ovf_pend_o | output | 1 | Overflow pending flag |
| count_o | output | 8 | Current count |

## Verification
Several rules are checked by the assertions on every cycle:
- the interval restart to zero;
- the increment and wrap of the free-running count;
- holding the count while disabled;
- the output toggle at each interval match;
- the low output in frame 3 past the reference;
- the clearing and stickiness of the flags;
- the shadow registers holding between loads.

Other behaviour only shows over whole scenarios in the bench. This covers the per-frame high-time counts for each extension pattern, and the exact clock on which a mid-frame reference write becomes visible. It also covers the interaction of mode switches with the toggle state and the acknowledge paths of the overflow flag.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic {
    MODE_INTERVAL = 1'b0,
    MODE_PWM      = 1'b1
  } pit_mode_e;

  localparam int unsigned FRAME_W = 2;

  // frame order that the 2-bit extension value spreads its extra clocks over
  function automatic logic stretch_sel(input logic [FRAME_W-1:0] frame,
                                       input logic [FRAME_W-1:0] ext);
    logic sel;
    case (frame)
      2'd0:    sel = ext[1];
      2'd1:    sel = ext[0];
      2'd2:    sel = ext[1];
      default: sel = 1'b0;
    endcase
    return sel;
  endfunction
endpackage

// File: rtl/pit_shadow.sv
module pit_shadow #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         load_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] buf_q, act_q, buf_nxt;

  assign buf_nxt = wr_i ? data_i : buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      buf_q <= buf_nxt;
      if (load_i) act_q <= buf_nxt;
    end
  end

  assign act_o = act_q;

  p_shadow_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q));
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               tick_i,
  input  logic               restart_i,
  input  logic               frame_adv_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      frame_q <= '0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      frame_q <= '0;
    end else begin
      if (tick_i) cnt_q <= restart_i ? '0 : cnt_q + 1'b1;
      if (frame_adv_i) frame_q <= frame_q + 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign frame_o = frame_q;

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(cnt_q));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && tick_i && !restart_i && cnt_q == CNT_MAX) |=> cnt_q == '0);

  p_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && tick_i && !restart_i && cnt_q != CNT_MAX)
      |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/pit_wave.sv
module pit_wave
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  pit_mode_e          mode_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [CNT_W-1:0]   ref_i,
  input  logic [FRAME_W-1:0] ext_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               toggle_i,
  output logic               out_o
);
  logic tog_q, pwm_q, level;

  // extra high clock lands on the count equal to the reference
  assign level = (ref_i > cnt_i) ||
                 ((cnt_i == ref_i) && stretch_sel(frame_i, ext_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q <= 1'b0;
      pwm_q <= 1'b0;
    end else if (clr_i) begin
      tog_q <= 1'b0;
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= level;
      if (toggle_i) tog_q <= ~tog_q;
    end
  end

  assign out_o = (mode_i == MODE_PWM) ? pwm_q : tog_q;

  p_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && toggle_i) |=> tog_q != $past(tog_q));

  p_toggle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !toggle_i) |=> $stable(tog_q));

  p_frame3_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && frame_i == 2'd3 && cnt_i >= ref_i) |=> !pwm_q);
endmodule

// File: rtl/pit_flags.sv
module pit_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic match_set_i,
  input  logic ovf_set_i,
  input  logic match_clr_i,
  input  logic ovf_clr_i,
  input  logic ovf_ack_i,
  output logic match_pend_o,
  output logic ovf_pend_o
);
  logic match_q, ovf_q;

  // a new event wins over a clear in the same clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (clr_i) begin
      match_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (match_set_i)      match_q <= 1'b1;
      else if (match_clr_i) match_q <= 1'b0;
      if (ovf_set_i)                  ovf_q <= 1'b1;
      else if (ovf_clr_i || ovf_ack_i) ovf_q <= 1'b0;
    end
  end

  assign match_pend_o = match_q;
  assign ovf_pend_o   = ovf_q;

  p_pend_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!match_q && !ovf_q));

  p_match_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_q && !match_clr_i && !clr_i) |=> match_q);

  p_ovf_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ovf_clr_i || ovf_ack_i) && !ovf_set_i) |=> !ovf_q);
endmodule

// File: rtl/pwm_interval_timer.sv
module pwm_interval_timer
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_clr_i,
  input  logic             cnt_en_i,
  input  logic             mode_i,
  input  logic             wr_ref_i,
  input  logic [CNT_W-1:0] ref_i,
  input  logic             wr_ext_i,
  input  logic [1:0]       ext_i,
  input  logic             match_clr_i,
  input  logic             ovf_clr_i,
  input  logic             ovf_ack_i,
  output logic             tmr_out_o,
  output logic             match_pend_o,
  output logic             ovf_pend_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  pit_mode_e          mode_q;
  logic               clr, tick, match_evt, restart, wrap_pwm, shadow_load;
  logic [CNT_W-1:0]   cnt, ref_act;
  logic [FRAME_W-1:0] frame, ext_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_INTERVAL;
    else         mode_q <= pit_mode_e'(mode_i);
  end

  assign clr         = sync_clr_i || (pit_mode_e'(mode_i) != mode_q);
  assign tick        = cnt_en_i && !clr;
  assign match_evt   = tick && (cnt == ref_act);
  assign restart     = match_evt && (mode_q == MODE_INTERVAL);
  assign wrap_pwm    = tick && (mode_q == MODE_PWM) && (cnt == CNT_MAX);
  assign shadow_load = clr || (mode_q == MODE_INTERVAL) || wrap_pwm;

  pit_shadow #(.W(CNT_W)) u_ref_shadow (
    .clk_i, .rst_ni, .wr_i(wr_ref_i), .data_i(ref_i),
    .load_i(shadow_load), .act_o(ref_act)
  );

  pit_shadow #(.W(FRAME_W)) u_ext_shadow (
    .clk_i, .rst_ni, .wr_i(wr_ext_i), .data_i(ext_i),
    .load_i(shadow_load), .act_o(ext_act)
  );

  pit_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i(tick), .restart_i(restart),
    .frame_adv_i(wrap_pwm), .cnt_o(cnt), .frame_o(frame)
  );

  pit_wave #(.CNT_W(CNT_W)) u_wave (
    .clk_i, .rst_ni, .clr_i(clr), .mode_i(mode_q), .cnt_i(cnt),
    .ref_i(ref_act), .ext_i(ext_act), .frame_i(frame),
    .toggle_i(restart), .out_o(tmr_out_o)
  );

  pit_flags u_flags (
    .clk_i, .rst_ni, .clr_i(clr), .match_set_i(match_evt),
    .ovf_set_i(wrap_pwm), .match_clr_i, .ovf_clr_i, .ovf_ack_i,
    .match_pend_o, .ovf_pend_o
  );

  assign count_o = cnt;

  p_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> count_o == '0);

  p_no_ovf_interval_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_INTERVAL && !ovf_pend_o) |=> !ovf_pend_o);

  p_frame_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !clr) |=> ($stable(frame) && $stable(count_o)));
endmodule

// File: tb/test_pwm_interval_timer.sv
module test_pwm_interval_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_clr = 0, cnt_en = 0, mode = 0, wr_ref = 0, wr_ext = 0;
  logic match_clr = 0, ovf_clr = 0, ovf_ack = 0;
  logic [7:0] ref_d = '0;
  logic [1:0] ext_d = '0;
  logic out, match_pend, ovf_pend;
  logic [7:0] count;
  int n_chk = 0, n_err = 0;
  bit done = 0;
  int hi [4];

  always #5 clk = ~clk;

  pwm_interval_timer i_pwm_interval_timer (
    .clk_i(clk), .rst_ni(rst_n), .sync_clr_i(sync_clr), .cnt_en_i(cnt_en),
    .mode_i(mode), .wr_ref_i(wr_ref), .ref_i(ref_d), .wr_ext_i(wr_ext),
    .ext_i(ext_d), .match_clr_i(match_clr), .ovf_clr_i(ovf_clr),
    .ovf_ack_i(ovf_ack), .tmr_out_o(out), .match_pend_o(match_pend),
    .ovf_pend_o(ovf_pend), .count_o(count)
  );

  // {ref, ext, high clocks in frames 0..3}
  localparam logic [45:0] VEC [0:6] = '{
    {8'h80, 2'b00, 9'd128, 9'd128, 9'd128, 9'd128},
    {8'h80, 2'b01, 9'd128, 9'd129, 9'd128, 9'd128},
    {8'h80, 2'b10, 9'd129, 9'd128, 9'd129, 9'd128},
    {8'h80, 2'b11, 9'd129, 9'd129, 9'd129, 9'd128},
    {8'h00, 2'b11, 9'd1,   9'd1,   9'd1,   9'd0  },
    {8'hFF, 2'b10, 9'd256, 9'd255, 9'd256, 9'd255},
    {8'h01, 2'b00, 9'd1,   9'd1,   9'd1,   9'd1  }
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic m, input logic [7:0] r, input logic [1:0] e);
    @(negedge clk);
    mode = m; sync_clr = 1; cnt_en = 0;
    wr_ref = 1; ref_d = r; wr_ext = 1; ext_d = e;
    @(negedge clk);
    sync_clr = 0; wr_ref = 0; wr_ext = 0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1;
    @(negedge clk);
    sig = 0;
  endtask

  task automatic measure_frames();
    cnt_en = 1;
    for (int f = 0; f < 4; f++) begin
      hi[f] = 0;
      for (int k = 0; k < 256; k++) begin
        @(negedge clk);
        hi[f] += int'(out);
      end
    end
    cnt_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check("R9 reset count", count, 0);
    check("R9 reset out", out, 0);
    check("R9 reset match_pend", match_pend, 0);
    check("R9 reset ovf_pend", ovf_pend, 0);

    // R4 R5: table of PWM patterns
    for (int v = 0; v < 7; v++) begin
      setup(1'b1, VEC[v][45:38], VEC[v][37:36]);
      measure_frames();
      for (int f = 0; f < 4; f++)
        check($sformatf("R4/R5 vec%0d frame%0d high clocks", v, f),
              hi[f], int'(VEC[v][35-9*f -: 9]));
    end

    // R1 R2 R6 interval mode with reference 10H
    setup(1'b0, 8'h10, 2'b00);
    cnt_en = 1;
    repeat (16) @(negedge clk);
    check("R1 count before match", count, 16);
    check("R6 no pend before match", match_pend, 0);
    @(negedge clk);
    check("R1 count restarts", count, 0);
    check("R6 match pend set", match_pend, 1);
    check("R2 first toggle", out, 1);
    repeat (17) @(negedge clk);
    check("R2 second toggle", out, 0);
    check("R7 no overflow in interval", ovf_pend, 0);
    repeat (5) @(negedge clk);
    cnt_en = 0;
    check("R10 count before hold", count, 5);
    repeat (5) @(negedge clk);
    check("R10 count held", count, 5);
    check("R6 pend sticky", match_pend, 1);
    pulse(match_clr);
    check("R6 pend cleared by strobe", match_pend, 0);

    // R8 interval write takes effect at once
    pulse(wr_ref);
    ref_d = 8'h08;
    wr_ref = 1;
    @(negedge clk);
    wr_ref = 0;
    cnt_en = 1;
    repeat (3) @(negedge clk);
    check("R8 count reaches new ref", count, 8);
    check("R8 no match yet", match_pend, 0);
    @(negedge clk);
    check("R8 restart at new ref", count, 0);
    check("R2 toggle on new ref", out, 1);

    // R9 synchronous clear
    sync_clr = 1;
    @(negedge clk);
    sync_clr = 0;
    cnt_en = 0;
    check("R9 sync clr count", count, 0);
    check("R9 sync clr out", out, 0);
    check("R9 sync clr pend", match_pend, 0);

    // R9 mode change
    cnt_en = 1;
    repeat (9) @(negedge clk);
    cnt_en = 0;
    check("R2 out high before switch", out, 1);
    mode = 1;
    @(negedge clk);
    check("R9 mode switch out", out, 0);
    check("R9 mode switch pend", match_pend, 0);
    check("R9 mode switch count", count, 0);

    // R3 R6 R7 PWM overflow handling
    setup(1'b1, 8'h10, 2'b00);
    cnt_en = 1;
    repeat (32) @(negedge clk);
    check("R3 match does not clear", count, 32);
    check("R6 match pend in PWM", match_pend, 1);
    repeat (223) @(negedge clk);
    check("R3 count at FF", count, 255);
    check("R7 no overflow yet", ovf_pend, 0);
    @(negedge clk);
    check("R3 wrap to 0", count, 0);
    check("R7 overflow set", ovf_pend, 1);
    cnt_en = 0;
    pulse(ovf_ack);
    check("R7 ack clears", ovf_pend, 0);
    cnt_en = 1;
    repeat (256) @(negedge clk);
    cnt_en = 0;
    check("R7 overflow set again", ovf_pend, 1);
    pulse(ovf_clr);
    check("R7 software clear", ovf_pend, 0);

    // R8 PWM reference write waits for the frame wrap
    setup(1'b1, 8'h40, 2'b00);
    cnt_en = 1;
    for (int f = 0; f < 2; f++) begin
      hi[f] = 0;
      for (int k = 0; k < 256; k++) begin
        @(negedge clk);
        hi[f] += int'(out);
        if (f == 0 && k == 7) begin wr_ref = 1; ref_d = 8'h80; end
        if (f == 0 && k == 8) wr_ref = 0;
      end
    end
    cnt_en = 0;
    check("R8 old ref kept in frame", hi[0], 64);
    check("R8 new ref after wrap", hi[1], 128);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule